// File: doc/BRIEF.md
# Quadrature to up/down pulse converter

This block turns the two phase-shifted square waves of an incremental encoder into count pulses for a plain up/down counter. Each encoder line passes through a two-flop synchroniser and a glitch filter. The filter accepts a new level only after that level has been seen on a set number of consecutive clock samples. A decoder compares the filtered phase pair with the pair it last tracked. It classifies each single-bit step as forward or reverse. A resolution select decides which steps produce a pulse.

A pulse stretcher drives one of two active-low outputs for a programmed number of clock cycles. While a pulse is being stretched, the decoder keeps following the encoder state but issues nothing. Encoder dither around a single edge therefore cannot generate count pairs. A step that changes both phases at once is impossible for a healthy encoder. Such a step raises a one-cycle error flag instead of a pulse.

Top module: `qenc_pulse_conv`

## Requirements
- R1: While `rst` is high, `up_n` and `dn_n` are 1 and `skip_err` is 0. The pulse width is captured from `width_cfg` during reset, and later changes of `width_cfg` have no effect until the next reset.
- R2: A level on `a_in` or `b_in` is accepted only after it has been sampled on FILT_N consecutive clock edges after synchronisation. A level that lasts fewer samples than that is discarded and produces no pulse.
- R3: A pulse output goes low on the (FILT_N+3)-th rising clock edge after the input change: two synchroniser stages, FILT_N filter samples, then one output register.
- R4: The phase state is written {A,B}. The forward sequence 00→10→11→01→00, in which A leads B, produces pulses on `up_n`. The reverse sequence 00→01→11→10→00, in which A lags B, produces pulses on `dn_n`.
- R5: With `res_sel`=0 (x1), a pulse is issued only on a rising step of A. That gives one pulse per quadrature cycle.
- R6: With `res_sel`=1 (x2), a pulse is issued on every step of A and on no step of B. That gives two pulses per cycle.
- R7: With `res_sel`=2 or 3 (x4), a pulse is issued on every step of A or B. That gives four pulses per cycle.
- R8: Each pulse stays low for exactly W clock cycles, where W is the captured width. A captured width of 0 gives one cycle.
- R9: A phase step accepted while either output is low produces no pulse, but it still updates the tracked state. The two outputs are never low together, and no pulse starts while the other output is low.
- R10: An accepted step in which A and B both change drives `skip_err` high for one cycle, in the cycle where a pulse would have started. It produces no pulse, and the tracked state still follows the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset; also captures the width |
| a_in | input | 1 | Encoder phase A, asynchronous |
| b_in | input | 1 | Encoder phase B, asynchronous |
| res_sel | input | 2 | Resolution: 0 = x1, 1 = x2, 2 or 3 = x4 |
| width_cfg | input | WIDTH_W | Pulse width in clock cycles, captured during reset |
| up_n | output | 1 | Active-low count-up pulse |
| dn_n | output | 1 | Active-low count-down pulse |
| skip_err | output | 1 | One-cycle flag for a step that changes both phases |

## Verification
The bench builds the block with FILT_N=3 and WIDTH_W=4. With these values every legal width, including the zero-to-one case, can be reached with short runs. The filter threshold is also short enough to probe a level held one sample too briefly next to one held just long enough. A sweep covers all four resolution codes, both rotation directions and the widths 0, 1, 3 and 15. It counts pulses against arithmetic expectations and measures every pulse length. Directed runs place an input change inside a long pulse, measure the edge-exact latency, and drive both phases together in one step.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_X4B = 2'd3
  } res_e;

  // Does a single-bit phase step qualify for a pulse at this resolution?
  function automatic logic step_counts(input logic [1:0] sel, input logic a_chg,
                                       input logic b_chg, input logic a_new);
    case (sel)
      RES_X1:  return a_chg && a_new;
      RES_X2:  return a_chg;
      default: return a_chg || b_chg;
    endcase
  endfunction
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CNT_W = $clog2(FILT_N + 1);

  logic             s1, s2;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      cnt   <= '0;
      level <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == level) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_N - 1)) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic [1:0] ph,      // {A,B} filtered
  input  logic [1:0] res_sel,
  output logic       fire_up,
  output logic       fire_dn,
  output logic       skip
);
  logic [1:0] prev;
  logic       a_chg, b_chg, dir_up, qual;

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b00;
    else     prev <= ph;   // tracks even while busy, so dither is absorbed
  end

  always_comb begin
    a_chg   = ph[1] ^ prev[1];
    b_chg   = ph[0] ^ prev[0];
    skip    = a_chg && b_chg;
    dir_up  = a_chg ? (ph[1] != ph[0]) : (ph[0] == ph[1]);
    qual    = !busy && !skip && step_counts(res_sel, a_chg, b_chg, ph[1]);
    fire_up = qual && dir_up;
    fire_dn = qual && !dir_up;
  end
endmodule

// File: rtl/qpc_pulse.sv
module qpc_pulse #(
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH_W-1:0] width_cfg,
  input  logic               fire_up,
  input  logic               fire_dn,
  input  logic               skip_in,
  output logic               up_n,
  output logic               dn_n,
  output logic               skip_err,
  output logic               busy
);
  logic [WIDTH_W-1:0] wreg, cnt, wlen;

  assign wlen = (wreg == '0) ? WIDTH_W'(1) : wreg;
  assign busy = !(up_n && dn_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg     <= width_cfg;
      cnt      <= '0;
      up_n     <= 1'b1;
      dn_n     <= 1'b1;
      skip_err <= 1'b0;
    end else begin
      skip_err <= skip_in;
      if (!busy) begin
        if (fire_up) begin
          up_n <= 1'b0;
          cnt  <= wlen - 1'b1;
        end else if (fire_dn) begin
          dn_n <= 1'b0;
          cnt  <= wlen - 1'b1;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        up_n <= 1'b1;
        dn_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qenc_pulse_conv.sv
module qenc_pulse_conv #(
  parameter int FILT_N  = 3,
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_in,
  input  logic               b_in,
  input  logic [1:0]         res_sel,
  input  logic [WIDTH_W-1:0] width_cfg,
  output logic               up_n,
  output logic               dn_n,
  output logic               skip_err
);
  logic [1:0] raw, ph;
  logic       fire_up, fire_dn, skip, busy;

  assign raw = {a_in, b_in};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    qpc_filter #(.FILT_N(FILT_N)) u_filt (
      .clk(clk), .rst(rst), .raw(raw[i]), .level(ph[i])
    );
  end

  qpc_decode u_dec (
    .clk(clk), .rst(rst), .busy(busy), .ph(ph), .res_sel(res_sel),
    .fire_up(fire_up), .fire_dn(fire_dn), .skip(skip)
  );

  qpc_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
    .clk(clk), .rst(rst), .width_cfg(width_cfg),
    .fire_up(fire_up), .fire_dn(fire_dn), .skip_in(skip),
    .up_n(up_n), .dn_n(dn_n), .skip_err(skip_err), .busy(busy)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [WIDTH_W-1:0] width_cfg,
  input logic               up_n,
  input logic               dn_n,
  input logic               skip_err
);
  logic [WIDTH_W-1:0] wl;
  logic [WIDTH_W:0]   run, expw;

  assign expw = (wl == '0) ? (WIDTH_W+1)'(1) : {1'b0, wl};

  always_ff @(posedge clk) begin
    if (rst) begin
      wl  <= width_cfg;
      run <= '0;
    end else if (!up_n || !dn_n) begin
      run <= run + 1'b1;
    end else begin
      run <= '0;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (up_n && dn_n && !skip_err));

  a_r8_pulse_length: assert property (@(posedge clk) disable iff (rst)
    ($rose(up_n) || $rose(dn_n)) |-> (run == expw));

  a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
    !(!up_n && !dn_n));

  a_r9_up_waits: assert property (@(posedge clk) disable iff (rst)
    $fell(up_n) |-> $past(dn_n));

  a_r9_dn_waits: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_n) |-> $past(up_n));

  a_r10_skip_silent: assert property (@(posedge clk) disable iff (rst)
    skip_err |-> (!$fell(up_n) && !$fell(dn_n)));

  a_r10_skip_single: assert property (@(posedge clk) disable iff (rst)
    skip_err |=> !skip_err);
endmodule

bind qenc_pulse_conv qpc_checker #(.WIDTH_W(WIDTH_W)) u_qpc_chk (
  .clk(clk), .rst(rst), .width_cfg(width_cfg),
  .up_n(up_n), .dn_n(dn_n), .skip_err(skip_err)
);

// File: tb/qenc_pulse_conv_bench.sv
module qenc_pulse_conv_bench;
  localparam int FILT_N  = 3;
  localparam int WIDTH_W = 4;
  localparam int GAP     = 30;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               a_in = 1'b0, b_in = 1'b0;
  logic [1:0]         res_sel = 2'd0;
  logic [WIDTH_W-1:0] width_cfg = '0;
  logic               up_n, dn_n, skip_err;

  int checks = 0, errors = 0;
  int ups = 0, dns = 0, skips = 0, runlen = 0, exp_w = 1;
  logic prev_low = 1'b0, prev_up = 1'b1, prev_dn = 1'b1;

  always #2.5 clk = ~clk;

  qenc_pulse_conv #(.FILT_N(FILT_N), .WIDTH_W(WIDTH_W)) u_qenc_pulse_conv (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .res_sel(res_sel),
    .width_cfg(width_cfg), .up_n(up_n), .dn_n(dn_n), .skip_err(skip_err)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Pulse monitor: counts pulse starts, skip flags, and measures every pulse (R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_up && !up_n) ups++;
      if (prev_dn && !dn_n) dns++;
      if (skip_err) skips++;
      if (!up_n || !dn_n) runlen++;
      else if (prev_low) begin
        check("R8 pulse width", runlen, exp_w);
        runlen = 0;
      end
      prev_low = !up_n || !dn_n;
      prev_up  = up_n;
      prev_dn  = dn_n;
    end
  end

  task automatic do_reset(input logic [1:0] mode, input int w);
    @(negedge clk);
    rst = 1'b1; a_in = 1'b0; b_in = 1'b0;
    res_sel = mode; width_cfg = WIDTH_W'(w);
    repeat (3) @(negedge clk);
    check("R1 up_n idle in reset", int'(up_n), 1);
    check("R1 dn_n idle in reset", int'(dn_n), 1);
    check("R1 skip_err idle in reset", int'(skip_err), 0);
    rst = 1'b0;
    width_cfg = ~WIDTH_W'(w);          // R1: must be ignored after reset
    exp_w = (w == 0) ? 1 : w;
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    a_in = a; b_in = b;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int u0, d0, s0, n;
    int widths[4] = '{0, 1, 3, 15};

    // Sweep: R4..R8 over modes, directions, widths
    for (int m = 0; m < 4; m++) begin
      for (int wi = 0; wi < 4; wi++) begin
        for (int dir = 0; dir < 2; dir++) begin
          int f;
          f = (m == 0) ? 1 : (m == 1) ? 2 : 4;
          do_reset(2'(m), widths[wi]);
          u0 = ups; d0 = dns;
          for (int k = 0; k < 2; k++) begin
            if (dir == 0) begin
              step(1, 0); step(1, 1); step(0, 1); step(0, 0);
            end else begin
              step(0, 1); step(1, 1); step(1, 0); step(0, 0);
            end
          end
          if (dir == 0) begin
            check("R4/R5/R6/R7 forward up count", ups - u0, 2 * f);
            check("R4 forward gives no down", dns - d0, 0);
          end else begin
            check("R4/R5/R6/R7 reverse down count", dns - d0, 2 * f);
            check("R4 reverse gives no up", ups - u0, 0);
          end
        end
      end
    end

    // R2: glitch one sample short is dropped, exact length is accepted
    do_reset(2'd2, 1);
    u0 = ups; d0 = dns;
    @(negedge clk); a_in = 1'b1;
    repeat (FILT_N - 1) @(negedge clk);
    a_in = 1'b0;
    repeat (GAP) @(negedge clk);
    check("R2 short glitch ignored up", ups - u0, 0);
    check("R2 short glitch ignored dn", dns - d0, 0);
    @(negedge clk); a_in = 1'b1;
    repeat (FILT_N) @(negedge clk);
    a_in = 1'b0;
    repeat (GAP) @(negedge clk);
    check("R2 full length accepted up", ups - u0, 1);
    check("R2 full length accepted dn", dns - d0, 1);

    // R3: latency from input change to pulse start
    do_reset(2'd2, 3);
    @(negedge clk); a_in = 1'b1;
    n = 0;
    while (up_n && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R3 latency in clocks", n, FILT_N + 3);
    repeat (GAP) @(negedge clk);

    // R9: a step back during a long pulse is absorbed
    do_reset(2'd2, 10);
    u0 = ups; d0 = dns;
    @(negedge clk); a_in = 1'b1;
    while (up_n) @(negedge clk);
    a_in = 1'b0;
    repeat (GAP) @(negedge clk);
    check("R9 lockout single up", ups - u0, 1);
    check("R9 lockout no down", dns - d0, 0);
    step(1, 0);                          // tracked state is 00 again: counts up
    check("R9 state tracked during lockout", ups - u0, 2);

    // R10: both phases change together
    do_reset(2'd2, 2);
    u0 = ups; d0 = dns; s0 = skips;
    step(1, 1);
    check("R10 skip flagged", skips - s0, 1);
    step(0, 0);
    check("R10 second skip flagged", skips - s0, 2);
    check("R10 no up on skip", ups - u0, 0);
    check("R10 no down on skip", dns - d0, 0);
    step(1, 0);                          // 00 -> 10 after tracking: up
    check("R10 state followed after skip", ups - u0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule